// File: doc/BRIEF.md
# Up/Down Timer with Step-Qualified Compare Match

This block is a 16-bit timer that counts up or down, one step per cycle in which its count enable is high. A synchronous clear input, driven by an event elsewhere in the chip, returns it to zero. A load port lets software write any value into it. A single compare channel holds a compare value and an enable bit. It raises a one-cycle match pulse when the timer arrives at the compare value by taking a counting step.

A clear or a load that puts the timer on the compare value is not a counting step, so it never raises a match. Writing the compare register never raises a match either, even when the new value equals the timer. When a clear and a load arrive in the same cycle, the clear wins and the load is dropped. The outcome of that collision is therefore fixed.

The timer wraps modulo 2^16 in both directions. The match pulse is registered on the same clock edge that moves the timer onto the compare value, so it sits beside the new count for exactly one cycle.

Top module: `count_match_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge sets `tmr_q` to 0, `cmp_q` to 0, `cmp_en_q` to 0 and `match_o` to 0.
- R2: When `tmr_clr` and `ld_we` are both low, an edge with `cnt_en` high moves `tmr_q` by one. The step is +1 when `cnt_down` is 0 and −1 when `cnt_down` is 1, wrapping modulo 2^16. An edge with `cnt_en` low leaves `tmr_q` unchanged.
- R3: An edge with `tmr_clr` high sets `tmr_q` to 0, whatever `ld_we`, `ld_val` and `cnt_en` are.
- R4: An edge with `ld_we` high and `tmr_clr` low sets `tmr_q` to `ld_val`, and `cnt_en` is ignored.
- R5: If a counting step (R2 with `cnt_en` high) moves `tmr_q` to the compare value held before the edge, and `cmp_en_q` was 1 before the edge, `match_o` is 1 for the cycle after that edge. In every other case `match_o` is 0.
- R6: A load whose value equals the compare value produces no match.
- R7: A clear while the compare value is 0 produces no match.
- R8: A counting step that wraps (0xFFFF up to 0x0000, or 0x0000 down to 0xFFFF) onto the compare value produces a match.
- R9: An edge with `cmp_we` high loads `cmp_wdata` into `cmp_q` and `cen_wdata` into `cmp_en_q`. The new value takes effect for steps on later edges, not the step on that same edge. The write produces no match by itself, even when `cmp_wdata` equals `tmr_q`.
- R10: While `cmp_en_q` is 0 no match is produced, and the timer keeps counting as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable, one step per cycle |
| cnt_down | input | 1 | Direction: 0 up, 1 down |
| tmr_clr | input | 1 | Event clear of the timer to zero |
| ld_we | input | 1 | Software load strobe |
| ld_val | input | 16 | Value to load |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | New compare value |
| cen_wdata | input | 1 | New compare enable bit |
| tmr_q | output | 16 | Current timer value |
| cmp_q | output | 16 | Current compare value |
| cmp_en_q | output | 1 | Current compare enable |
| match_o | output | 1 | One-cycle match pulse |

## Verification
A wrong step qualifier shows up at `match_o` in the cycle right after a load, clear or compare write that lands on the compare value. The directed cases therefore create each of those coincidences on purpose. A wrong count, wrap or clear/load priority shows up on `tmr_q` one edge after the stimulus. The bench compares `tmr_q` on every cycle, so such a fault is caught at the first edge where it occurs. A compare register that updates too early or too late shows up as a pulse one step off. The bench checks this by writing the compare value in the same cycle as a step that reaches the old value.

// File: rtl/cmt_pkg.sv
// Shared types for the step-qualified compare timer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cmt_pkg;

    // What the timer register does on the coming edge, highest priority first.
    typedef enum logic [1:0] {
        TOP_CLEAR = 2'd0,
        TOP_LOAD  = 2'd1,
        TOP_STEP  = 2'd2,
        TOP_HOLD  = 2'd3
    } tmr_op_e;

    // Resolve the per-cycle operation; clear beats load beats counting.
    function automatic tmr_op_e resolve_op(input logic clr, input logic ld, input logic en);
        if (clr)     return TOP_CLEAR;
        else if (ld) return TOP_LOAD;
        else if (en) return TOP_STEP;
        else         return TOP_HOLD;
    endfunction

endpackage

// File: rtl/cmt_counter.sv
// Timer register: counts up or down by one, is cleared by an event or
// loaded by software. Clear takes precedence over a load in the same cycle.
// Exposes the value it will hold after the next edge and whether that value
// comes from a counting step, for use by the compare channel.
// Assumes: synchronous active-low reset; counting wraps modulo 2^W.
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         cnt_down,
    input  logic         tmr_clr,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] tmr_q,
    output logic [W-1:0] tmr_nxt,
    output logic         stepped
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};

    tmr_op_e     op;
    logic [W-1:0] step_val;

    // Pick this cycle's operation from the strobes.
    always_comb begin
        op = resolve_op(tmr_clr, ld_we, cnt_en);
    end

    // Compute the one-step neighbour in the requested direction.
    always_comb begin
        step_val = cnt_down ? (tmr_q - UNIT) : (tmr_q + UNIT);
    end

    // Form the next timer value and flag whether it is a counting step.
    always_comb begin
        stepped = 1'b0;
        unique case (op)
            TOP_CLEAR: tmr_nxt = ZERO;
            TOP_LOAD:  tmr_nxt = ld_val;
            TOP_STEP: begin
                tmr_nxt = step_val;
                stepped = 1'b1;
            end
            default:   tmr_nxt = tmr_q;
        endcase
    end

    // Timer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= ZERO;
        else        tmr_q <= tmr_nxt;
    end

endmodule

// File: rtl/cmt_compare.sv
// Compare channel: holds the compare value and enable, and registers a
// one-cycle match pulse when a counting step brings the timer onto the
// compare value. Loads, clears and compare writes never match.
// Assumes: the step compares against the value held before the edge, so a
// compare write applies from the following step on.
module cmt_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cen_wdata,
    input  logic         stepped,
    input  logic [W-1:0] tmr_nxt,
    output logic [W-1:0] cmp_q,
    output logic         cmp_en_q,
    output logic         match_o
);

    logic hit;

    // Decide whether the coming edge is a qualified match.
    always_comb begin
        hit = stepped && cmp_en_q && (tmr_nxt == cmp_q);
    end

    // Compare value and enable register, written as one unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            cmp_en_q <= 1'b0;
        end else if (cmp_we) begin
            cmp_q    <= cmp_wdata;
            cmp_en_q <= cen_wdata;
        end
    end

    // Match pulse register, aligned with the timer's own update.
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= 1'b0;
        else        match_o <= hit;
    end

endmodule

// File: rtl/count_match_timer.sv
// Up/down timer with a single compare channel whose match fires only on a
// counting step. Top level: wires the timer register to the compare channel.
// Assumes: one clock, synchronous active-low reset, all inputs synchronous.
module count_match_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         cnt_down,
    input  logic         tmr_clr,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cen_wdata,
    output logic [W-1:0] tmr_q,
    output logic [W-1:0] cmp_q,
    output logic         cmp_en_q,
    output logic         match_o
);

    logic [W-1:0] tmr_nxt;
    logic         stepped;

    cmt_counter #(.W(W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .cnt_down (cnt_down),
        .tmr_clr  (tmr_clr),
        .ld_we    (ld_we),
        .ld_val   (ld_val),
        .tmr_q    (tmr_q),
        .tmr_nxt  (tmr_nxt),
        .stepped  (stepped)
    );

    cmt_compare #(.W(W)) i_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .cen_wdata (cen_wdata),
        .stepped   (stepped),
        .tmr_nxt   (tmr_nxt),
        .cmp_q     (cmp_q),
        .cmp_en_q  (cmp_en_q),
        .match_o   (match_o)
    );

endmodule

// File: rtl/cmt_checker.sv
// Port-level properties of the step-qualified compare timer, bound to the top.
// Assumes: synchronous active-low reset; all properties are off during reset.
module cmt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         cnt_down,
    input logic         tmr_clr,
    input logic         ld_we,
    input logic [W-1:0] ld_val,
    input logic         cmp_we,
    input logic [W-1:0] cmp_wdata,
    input logic         cen_wdata,
    input logic [W-1:0] tmr_q,
    input logic [W-1:0] cmp_q,
    input logic         cmp_en_q,
    input logic         match_o
);

    logic step_up, step_dn, idle;
    always_comb begin
        step_up = cnt_en && !tmr_clr && !ld_we && !cnt_down;
        step_dn = cnt_en && !tmr_clr && !ld_we && cnt_down;
        idle    = !cnt_en && !tmr_clr && !ld_we;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) tmr_clr |=> (tmr_q == '0)); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (ld_we && !tmr_clr) |=> (tmr_q == $past(ld_val))); // R4
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n) step_up |=> (tmr_q == W'($past(tmr_q) + 1'b1))); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n) step_dn |=> (tmr_q == W'($past(tmr_q) - 1'b1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) idle |=> $stable(tmr_q)); // R2
    AST_MATCH_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n) (match_o && $past(rst_n)) |-> $past(cnt_en && !tmr_clr && !ld_we)); // R6
    AST_MATCH_ON_VALUE: assert property (@(posedge clk) disable iff (!rst_n) (match_o && $past(rst_n)) |-> (tmr_q == $past(cmp_q))); // R5
    AST_MATCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) (match_o && $past(rst_n)) |-> $past(cmp_en_q)); // R10
    AST_WRAP_UP_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (step_up && cmp_en_q && (W'(tmr_q + 1'b1) == cmp_q)) |=> match_o); // R8
    AST_CMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cmp_we |=> ((cmp_q == $past(cmp_wdata)) && (cmp_en_q == $past(cen_wdata)))); // R9

endmodule

bind count_match_timer cmt_checker #(.W(W)) i_chk (.*);

// File: tb/test_count_match_timer.sv
// Bench for the step-qualified compare timer: directed corners and a
// fixed-seed random run, checked against a reference model in the bench.
module test_count_match_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, cnt_down = 1'b0, tmr_clr = 1'b0, ld_we = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         cen_wdata = 1'b0;
    logic [W-1:0] tmr_q, cmp_q;
    logic         cmp_en_q, match_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state.
    logic [W-1:0] m_t = '0, m_c = '0;
    logic         m_e = 1'b0, m_m = 1'b0;

    always #4 clk = ~clk;

    count_match_timer #(.W(W)) i_count_match_timer (.*);

    function automatic logic [W-1:0] next_tmr(logic [W-1:0] t, logic en, logic dn,
                                              logic clr, logic ld, logic [W-1:0] lv);
        if (clr)     return '0;
        else if (ld) return lv;
        else if (en) return dn ? t - 1'b1 : t + 1'b1;
        else         return t;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check at the next falling edge.
    task automatic cyc(string req, logic en, logic dn, logic clr, logic ld, logic [W-1:0] lv,
                       logic cw, logic [W-1:0] cv, logic ce);
        logic [W-1:0] nt;
        logic         st;
        cnt_en = en; cnt_down = dn; tmr_clr = clr; ld_we = ld; ld_val = lv;
        cmp_we = cw; cmp_wdata = cv; cen_wdata = ce;
        @(posedge clk);
        if (!rst_n) begin
            m_t = '0; m_c = '0; m_e = 1'b0; m_m = 1'b0;
        end else begin
            st  = en && !clr && !ld;
            nt  = next_tmr(m_t, en, dn, clr, ld, lv);
            m_m = st && m_e && (nt == m_c);
            if (cw) begin m_c = cv; m_e = ce; end
            m_t = nt;
        end
        @(negedge clk);
        check(req, "tmr_q", tmr_q, m_t);
        check(req, "match_o", W'(match_o), W'(m_m));
        check(req, "cmp_q", cmp_q, m_c);
        check(req, "cmp_en_q", W'(cmp_en_q), W'(m_e));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = 32'd1357;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        cyc("R1", 1, 0, 0, 0, '0, 1, 16'h1234, 1);
        cyc("R1", 1, 0, 0, 1, 16'h55, 0, '0, 0);
        rst_n = 1'b1;
        // R2: count up then down, hold
        cyc("R2", 1, 0, 0, 0, '0, 0, '0, 0);
        cyc("R2", 1, 0, 0, 0, '0, 0, '0, 0);
        cyc("R2", 1, 1, 0, 0, '0, 0, '0, 0);
        cyc("R2", 0, 0, 0, 0, '0, 0, '0, 0);
        // R5: enable compare at 5, count up onto it
        cyc("R5", 0, 0, 0, 1, 16'd3, 1, 16'd5, 1);
        cyc("R5", 1, 0, 0, 0, '0, 0, '0, 0);
        cyc("R5", 1, 0, 0, 0, '0, 0, '0, 0);
        cyc("R5", 1, 0, 0, 0, '0, 0, '0, 0);
        // R5: down onto compare
        cyc("R5", 1, 1, 0, 0, '0, 0, '0, 0);
        // R6: load equal to compare value
        cyc("R6", 1, 0, 0, 1, 16'd5, 0, '0, 0);
        cyc("R6", 0, 0, 0, 0, '0, 0, '0, 0);
        // R7: clear with compare value 0
        cyc("R7", 0, 0, 0, 0, '0, 1, 16'd0, 1);
        cyc("R7", 1, 0, 1, 0, '0, 0, '0, 0);
        cyc("R7", 0, 0, 0, 0, '0, 0, '0, 0);
        // R3: clear and load in the same cycle
        cyc("R3", 1, 0, 0, 1, 16'h0AA0, 0, '0, 0);
        cyc("R3", 1, 0, 1, 1, 16'h1111, 0, '0, 0);
        // R4: load overrides counting
        cyc("R4", 1, 1, 0, 1, 16'hBEEF, 0, '0, 0);
        // R8: wrap down 0 -> FFFF onto compare
        cyc("R8", 0, 0, 1, 0, '0, 1, 16'hFFFF, 1);
        cyc("R8", 1, 1, 0, 0, '0, 0, '0, 0);
        // R8: wrap up FFFF -> 0 onto compare
        cyc("R8", 0, 0, 0, 0, '0, 1, 16'h0000, 1);
        cyc("R8", 1, 0, 0, 0, '0, 0, '0, 0);
        // R9: write compare equal to timer, no match
        cyc("R9", 0, 0, 0, 0, '0, 1, 16'h0000, 1);
        cyc("R9", 0, 0, 0, 0, '0, 0, '0, 0);
        // R9: write in the same cycle as a step onto the old value
        cyc("R9", 0, 0, 0, 0, '0, 1, 16'd1, 1);
        cyc("R9", 1, 0, 0, 0, '0, 1, 16'd9, 1);
        // R10: disabled compare, counting onto value
        cyc("R10", 0, 0, 0, 1, 16'd8, 1, 16'd9, 0);
        cyc("R10", 1, 0, 0, 0, '0, 0, '0, 0);
        cyc("R10", 1, 0, 0, 0, '0, 0, '0, 0);
        // Random run, compare kept near the timer to provoke matches (R2 R5 R6 R9).
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            cyc("R5", r[0] | r[1], r[2], (r[7:3] == 0), (r[12:8] < 3),
                m_t + W'(r[15:13]) - 16'd2, (r[20:16] < 2), m_t + W'(r[23:21]) - 16'd3,
                r[24] | r[25]);
        end
        summary();
    end

endmodule